// File: doc/BRIEF.md
# RTC Status and Control Register

This block is the status/control byte of a real-time-clock register file. It sits behind a byte-wide register access port that an upstream serial front end drives. The front end supplies an address, write data, one-cycle write and read strobes, and a one-cycle pulse when a bus transaction completes. Three hardware event pulses from the rest of the clock set three sticky flags. The flags report a start-up after every supply was lost, entry into battery backup, and an alarm match. Software can clear these flags but can never set them.

The byte also holds three control bits. One gates writes into the timekeeping registers, one selects an external 32 kHz clock in place of the crystal, and one enables automatic flag clearing. With automatic clearing on, a completed read clears the battery and alarm flags. A completed read is a read strobe on the register followed by the transaction-complete pulse. Only flag values that were already set when the read began are cleared, so an alarm that fires mid-read is not lost. After an accepted timekeeping write, the transaction-complete pulse produces a one-cycle restart pulse for the 1 Hz prescaler.

Bit layout of the byte: bit 0 power-loss flag, bit 1 battery flag, bit 2 alarm flag, bit 4 timekeeping write enable, bit 6 oscillator bypass, bit 7 auto-clear enable. Bits 3 and 5 read 0. The register is at address 7, and the timekeeping registers occupy addresses 0 to 6.

Top module: `rtc_stat_top`

## Requirements
- R1: After reset every bit of the byte is 0. `rdData`, `timeWrEn`, `oscBypass`, `autoClrEn`, `timeWrAllow` and `prescRestart` are all 0.
- R2: A pulse on `evPowerUp`, `evBattery` or `evAlarm` sets bit 0, bit 1 or bit 2 respectively at the next clock edge. `rdData` shows the byte whenever `busAddr` is 7 and shows 0 otherwise.
- R3: A write of 1 into bit 0 does not set the power-loss flag. The flag clears on an accepted write, which is either any write to address 7 or a timekeeping write that `timeWrAllow` admits. A timekeeping write that is blocked leaves the flag set.
- R4: Writing 0 to bit 1 or bit 2 clears that flag. Writing 1 to either bit has no effect.
- R5: When a hardware event and a clearing write (or an auto-clear) hit the same flag in the same cycle, the flag ends up 1.
- R6: With bit 7 at 1, a read strobe at address 7 followed later by `busStop` clears bits 1 and 2 if they were 1 at the read strobe.
- R7: With bit 7 at 0, a completed read leaves bits 1 and 2 unchanged.
- R8: An alarm event that arrives after the read strobe and before `busStop` leaves bit 2 at 1 after the auto-clear.
- R9: A read that never sees `busStop` leaves the flags unchanged. This includes a read abandoned because a new write starts before the stop.
- R10: `timeWrAllow` is 1 only while `busWr` is 1, `busAddr` is between 0 and 6, and bit 4 is 1.
- R11: `busStop` after an accepted timekeeping write raises `prescRestart` for exactly that cycle. A later stop with no new timekeeping write does not raise it.
- R12: Bits 4, 6 and 7 are loaded by writes to address 7 and drive `timeWrEn`, `oscBypass` and `autoClrEn`. Bits 3 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register address |
| busWData | input | 8 | Write data |
| busWr | input | 1 | Write strobe, one cycle |
| busRd | input | 1 | Read-start strobe, one cycle |
| busStop | input | 1 | Transaction-complete pulse |
| evPowerUp | input | 1 | Start-up after total supply loss |
| evBattery | input | 1 | Battery backup entered |
| evAlarm | input | 1 | Alarm match |
| rdData | output | 8 | Read data |
| timeWrEn | output | 1 | Timekeeping write enable bit |
| oscBypass | output | 1 | External clock select |
| autoClrEn | output | 1 | Auto-clear enable bit |
| timeWrAllow | output | 1 | Gated write strobe to timekeeping registers |
| prescRestart | output | 1 | Prescaler restart pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the register at address 7, and timekeeping registers at 0 to 6. This puts both ends of the timekeeping window and the first address outside it within reach. Those addresses are where the write gate, the power-loss clear and the prescaler restart must differ. The stimulus also brings several pulses into the same cycle on purpose: events together with clearing writes, a stop together with an auto-clear, and an alarm in the middle of a read. These collisions are where the ordering rules matter.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
  localparam int DATA_W    = 8;
  localparam int BIT_PFAIL = 0;
  localparam int BIT_BAT   = 1;
  localparam int BIT_ALM   = 2;
  localparam int BIT_TWE   = 4;
  localparam int BIT_OSC   = 6;
  localparam int BIT_AUTO  = 7;
  localparam logic [DATA_W-1:0] CTRL_MASK =
      DATA_W'((1 << BIT_TWE) | (1 << BIT_OSC) | (1 << BIT_AUTO));

  typedef struct packed {
    logic statSel;   // address hits the status byte
    logic statWr;    // write into the status byte
    logic rdStart;   // read of the status byte begins
    logic stopClr;   // completed read with auto-clear enabled
    logic acceptWr;  // any write the RTC section accepts
  } stat_stb_t;
endpackage

// File: rtl/rtc_stat_ctrl.sv
module rtc_stat_ctrl
  import rtc_stat_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_ADDR = 7,
  parameter int TIME_LAST = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busStop,
  input  logic              timeWrEn,
  input  logic              autoClrEn,
  output stat_stb_t         stb,
  output logic              timeWrAllow,
  output logic              prescRestart
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] TIME_A = ADDR_W'(TIME_LAST);

  logic rdPend;
  logic twPend;
  logic timeHit;

  always_comb begin
    timeHit      = (busAddr <= TIME_A);
    timeWrAllow  = busWr && timeHit && timeWrEn;
    stb.statSel  = (busAddr == STAT_A);
    stb.statWr   = busWr && stb.statSel;
    stb.rdStart  = busRd && stb.statSel;
    stb.stopClr  = busStop && rdPend && autoClrEn;
    stb.acceptWr = stb.statWr || timeWrAllow;
    prescRestart = busStop && twPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      twPend <= 1'b0;
    end else begin
      if (busStop || busWr) rdPend <= 1'b0;
      else if (stb.rdStart) rdPend <= 1'b1;
      if (busStop) twPend <= 1'b0;
      else if (timeWrAllow) twPend <= 1'b1;
    end
  end

  // a new write abandons any outstanding read
  p_write_aborts_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> !rdPend);
  // restart pulse is never stretched across two cycles
  p_restart_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    prescRestart |=> !prescRestart);
  // a restart needs a timekeeping write admitted earlier
  p_restart_needs_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(twPend) |-> $past(timeWrAllow));
endmodule

// File: rtl/rtc_stat_dp.sv
module rtc_stat_dp
  import rtc_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busWData,
  input  stat_stb_t         stb,
  input  logic              evPowerUp,
  input  logic              evBattery,
  input  logic              evAlarm,
  output logic [DATA_W-1:0] statByte
);
  logic              pwrFail;
  logic              batFlag;
  logic              almFlag;
  logic              snapBat;
  logic              snapAlm;
  logic [DATA_W-1:0] ctrlByte;
  logic              clrBat;
  logic              clrAlm;

  always_comb begin
    clrBat = (stb.statWr && !busWData[BIT_BAT]) || (stb.stopClr && snapBat);
    clrAlm = (stb.statWr && !busWData[BIT_ALM]) || (stb.stopClr && snapAlm);
    statByte = ctrlByte;
    statByte[BIT_PFAIL] = pwrFail;
    statByte[BIT_BAT]   = batFlag;
    statByte[BIT_ALM]   = almFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrFail  <= 1'b0;
      batFlag  <= 1'b0;
      almFlag  <= 1'b0;
      snapBat  <= 1'b0;
      snapAlm  <= 1'b0;
      ctrlByte <= '0;
    end else begin
      if (stb.rdStart) begin
        snapBat <= batFlag;
        snapAlm <= almFlag;
      end
      pwrFail <= evPowerUp || (pwrFail && !stb.acceptWr);
      batFlag <= evBattery || (batFlag && !clrBat);
      almFlag <= evAlarm   || (almFlag && !clrAlm);
      if (stb.statWr) ctrlByte <= busWData & CTRL_MASK;
    end
  end

  // software can never raise the power-loss flag
  p_pfail_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrFail) |-> $past(evPowerUp));
  // battery flag only rises on its event
  p_bat_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(batFlag) |-> $past(evBattery));
  // event wins over any clear in the same cycle
  p_set_priority_r5: assert property (@(posedge clk) disable iff (!rstN)
    evAlarm |=> almFlag);
  // alarm flag drops only by write or by clearing a value seen at read start
  p_alarm_survives_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(almFlag) |-> ($past(stb.statWr) || $past(stb.stopClr && snapAlm)));
  // battery flag never drops without a write or a completed read
  p_no_clear_without_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(batFlag) |-> ($past(stb.statWr) || $past(stb.stopClr)));
endmodule

// File: rtl/rtc_stat_top.sv
module rtc_stat_top
  import rtc_stat_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_ADDR = 7,
  parameter int TIME_LAST = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busStop,
  input  logic              evPowerUp,
  input  logic              evBattery,
  input  logic              evAlarm,
  output logic [DATA_W-1:0] rdData,
  output logic              timeWrEn,
  output logic              oscBypass,
  output logic              autoClrEn,
  output logic              timeWrAllow,
  output logic              prescRestart
);
  stat_stb_t         stb;
  logic [DATA_W-1:0] statByte;

  rtc_stat_ctrl #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .TIME_LAST(TIME_LAST)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busStop(busStop), .timeWrEn(timeWrEn), .autoClrEn(autoClrEn), .stb(stb),
    .timeWrAllow(timeWrAllow), .prescRestart(prescRestart));

  rtc_stat_dp u_dp (
    .clk(clk), .rstN(rstN), .busWData(busWData), .stb(stb),
    .evPowerUp(evPowerUp), .evBattery(evBattery), .evAlarm(evAlarm),
    .statByte(statByte));

  always_comb begin
    rdData    = stb.statSel ? statByte : '0;
    timeWrEn  = statByte[BIT_TWE];
    oscBypass = statByte[BIT_OSC];
    autoClrEn = statByte[BIT_AUTO];
  end

  // the gated timekeeping strobe never fires while the enable bit is low
  p_time_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    timeWrAllow |-> (busWr && statByte[BIT_TWE]));
endmodule

// File: tb/rtc_stat_top_bench.sv
`timescale 1ns/1ps
module rtc_stat_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0, busWData = '0;
  logic       busWr = 0, busRd = 0, busStop = 0;
  logic       evPowerUp = 0, evBattery = 0, evAlarm = 0;
  logic [7:0] rdData;
  logic       timeWrEn, oscBypass, autoClrEn, timeWrAllow, prescRestart;

  int    nVec = 0, nBad = 0;
  string curReq = "R1";
  bit    finished = 0;

  // reference state
  bit mPf, mBat, mAlm, mTwe, mOsc, mAc, mRdPend, mSnapB, mSnapA, mTwPend;

  always #2.5 clk = ~clk;

  rtc_stat_top u_rtc_stat_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWData(busWData),
    .busWr(busWr), .busRd(busRd), .busStop(busStop), .evPowerUp(evPowerUp),
    .evBattery(evBattery), .evAlarm(evAlarm), .rdData(rdData), .timeWrEn(timeWrEn),
    .oscBypass(oscBypass), .autoClrEn(autoClrEn), .timeWrAllow(timeWrAllow),
    .prescRestart(prescRestart));

  function automatic logic [7:0] refByte();
    return {mAc, mOsc, 1'b0, mTwe, 1'b0, mAlm, mBat, mPf};
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic cyc(logic [7:0] a, logic [7:0] d, bit wr, bit rd, bit st,
                     bit ep, bit eb, bit ea);
    bit statWr, timeOk, rdStart, stopClr;
    busAddr = a; busWData = d; busWr = wr; busRd = rd; busStop = st;
    evPowerUp = ep; evBattery = eb; evAlarm = ea;
    #1;
    timeOk = wr && (a <= 8'd6) && mTwe;
    chk("rdData", rdData, (a == 8'd7) ? refByte() : 8'h00);
    chk("controls", {5'd0, timeWrEn, oscBypass, autoClrEn}, {5'd0, mTwe, mOsc, mAc});
    chk("timeWrAllow", {7'd0, timeWrAllow}, {7'd0, timeOk});
    chk("prescRestart", {7'd0, prescRestart}, {7'd0, st && mTwPend});
    @(posedge clk);
    statWr  = wr && (a == 8'd7);
    rdStart = rd && (a == 8'd7);
    stopClr = st && mRdPend && mAc;
    if (rdStart) begin mSnapB = mBat; mSnapA = mAlm; end
    if ((statWr && !d[1]) || (stopClr && mSnapB)) mBat = 0;
    if ((statWr && !d[2]) || (stopClr && mSnapA)) mAlm = 0;
    if (eb) mBat = 1;
    if (ea) mAlm = 1;
    if (statWr || timeOk) mPf = 0;
    if (ep) mPf = 1;
    if (st || wr) mRdPend = 0; else if (rdStart) mRdPend = 1;
    if (st) mTwPend = 0; else if (timeOk) mTwPend = 1;
    if (statWr) begin mTwe = d[4]; mOsc = d[6]; mAc = d[7]; end
    @(negedge clk);
  endtask

  task automatic idle(int n, logic [7:0] a = 8'd7);
    for (int i = 0; i < n; i++) cyc(a, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wrReg(logic [7:0] a, logic [7:0] d);
    cyc(a, d, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1"; idle(3);
    curReq = "R2";
    cyc(7, 0, 0, 0, 0, 1, 0, 0);
    cyc(7, 0, 0, 0, 0, 0, 1, 0);
    cyc(7, 0, 0, 0, 0, 0, 0, 1);
    idle(2); idle(1, 8'd8);
    curReq = "R4";
    wrReg(7, 8'h06); idle(1);          // write 1s: no effect
    wrReg(7, 8'h04); idle(1);          // clear battery only
    wrReg(7, 8'h00); idle(1);          // clear alarm
    curReq = "R3";
    idle(1);                            // power-loss flag already cleared by writes
    cyc(7, 0, 0, 0, 0, 1, 0, 0);
    wrReg(3, 8'h55); idle(1);          // blocked timing write keeps flag
    wrReg(7, 8'h01); idle(1);          // writing 1 does not keep it set
    cyc(7, 0, 0, 0, 0, 1, 0, 0);
    curReq = "R5";
    cyc(7, 8'h00, 1, 0, 0, 1, 1, 1); idle(1);
    curReq = "R12";
    wrReg(7, 8'hFF); idle(2);
    wrReg(7, 8'h40); idle(1);
    curReq = "R10";
    wrReg(0, 8'h12); wrReg(6, 8'h12);
    wrReg(7, 8'h10);
    wrReg(0, 8'h12); wrReg(6, 8'h12); wrReg(8, 8'h12);
    cyc(6, 0, 0, 0, 0, 0, 0, 0);
    curReq = "R3";
    cyc(7, 0, 0, 0, 0, 1, 0, 0);
    wrReg(2, 8'h33); idle(1);          // accepted timing write clears flag
    curReq = "R11";
    cyc(2, 0, 0, 0, 1, 0, 0, 0);
    cyc(2, 0, 0, 0, 1, 0, 0, 0);
    wrReg(5, 8'h01); idle(2, 8'd5);
    cyc(5, 0, 0, 0, 1, 0, 0, 0); idle(1);
    curReq = "R7";
    cyc(7, 0, 0, 0, 0, 0, 1, 1);
    cyc(7, 0, 0, 1, 0, 0, 0, 0); idle(1);
    cyc(7, 0, 0, 0, 1, 0, 0, 0); idle(1);
    curReq = "R6";
    wrReg(7, 8'h86);
    cyc(7, 0, 0, 1, 0, 0, 0, 0); idle(2);
    cyc(7, 0, 0, 0, 1, 0, 0, 0); idle(2);
    curReq = "R8";
    cyc(7, 0, 0, 0, 0, 0, 1, 0);
    cyc(7, 0, 0, 1, 0, 0, 0, 0);
    cyc(7, 0, 0, 0, 0, 0, 0, 1);
    cyc(7, 0, 0, 0, 1, 0, 0, 0); idle(2);
    curReq = "R5";
    wrReg(7, 8'h80);
    cyc(7, 0, 0, 0, 0, 0, 1, 0);
    cyc(7, 0, 0, 1, 0, 0, 0, 0);
    cyc(7, 0, 0, 0, 1, 0, 1, 0); idle(1);
    curReq = "R9";
    cyc(7, 0, 0, 0, 0, 0, 0, 1);
    cyc(7, 0, 0, 1, 0, 0, 0, 0); idle(5);
    wrReg(8'h20, 8'h00);
    cyc(7, 0, 0, 0, 1, 0, 0, 0); idle(2);
    cyc(7, 0, 0, 0, 1, 0, 0, 0); idle(1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule